// File: doc/BRIEF.md
# AES Accelerator SPI Register Window

This block is the device-side SPI slave that puts an AES block engine on a byte-addressed register map. The SPI lines are sampled in the system clock domain, in SPI mode 0. Each transaction opens with a command byte, which selects read or write, and an address byte. The address then steps by one for every further byte until chip select goes high. The map holds a status register, a control register, a 16-byte window and a mirror of the control register.

The control mode field decides what the window means. In key mode, writes to the window load the cipher key, and reads return the last-round key. In the data modes, writes fill the input block and reads return the most recent result. A block runs when the mirror register is written with its request bit set. While the next block is being written, MISO carries the previous result one byte behind, so one write transaction both feeds a block and drains the one before it.

The cipher itself sits behind a start/done handshake. Here it is a placeholder transform with a parameterised latency: the result is the input XOR the key for encryption, or the input XOR the last-round key for decryption. The last-round key is the bitwise inverse of the written key.

Top module: `aesw_spi_slave`

## Requirements
- R1: After reset, status (0x82) and control (0x83) both read 0x00.
- R2: Command 0x00 reads: the byte after the address byte returns the register at that address, and each further byte returns the next address.
- R3: Command 0x40 writes starting at the given address, and the address steps by one per byte. Control and mirror (0x94) both read back as {0, mode[2:0], dir, 000}, with mode in bits 6:4 (0 ECB, 1 key, 2 CBC) and dir in bit 3 (1 = decrypt).
- R4: A mirror write with bit 7 set, after 16 window bytes (0x84..0x93) have been written since the last control write, starts the block. Status bit 0 (done) clears at once and sets LATENCY cycles later.
- R5: An ECB encryption result is input XOR key, and an ECB decryption result is input XOR the inverted key. Window reads in a data mode return the result, with byte k at 0x84+k.
- R6: During a write, the data byte to 0x84+k+1 (k = 0..14) shifts out result byte k on MISO, and the mirror byte shifts out result byte 15.
- R7: A mirror write with bit 7 clear starts nothing: done and the result are unchanged.
- R8: A request with fewer than 16 window bytes written sets status bit 7 (error) and starts nothing.
- R9: Writing control while a block is running sets the error bit.
- R10: In key mode, window writes load the key, and window reads return the bitwise inverse of the key.
- R11: In CBC mode, the input block is XORed with the previous result before it is transformed.
- R12: An accepted start clears both error and done.
- R13: A command byte other than 0x00 or 0x40 makes the rest of the transaction write nothing and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk | input | 1 | SPI clock (mode 0, idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data into the block |
| spi_miso | output | 1 | SPI data out of the block, low when deselected |

## Verification
The bench uses the default LATENCY of 1200 cycles, which is 24 us at 50 MHz, and two synchroniser stages, with SCK at one sixteenth of the system clock. At these settings a status read issued right after a start lands inside the busy window, so done is seen clear. A control rewrite can also be placed while the engine is still running, which exercises the error path. Pending block completion, the bench waits the full latency and then checks the done flag and the result.

// File: rtl/aesw_pkg.sv
package aesw_pkg;
  localparam int BLK_BYTES = 16;
  localparam int BLK_W     = BLK_BYTES * 8;
  localparam int CNT_W     = $clog2(BLK_BYTES + 1);

  localparam logic [7:0] CMD_RD     = 8'h00;
  localparam logic [7:0] CMD_WR     = 8'h40;
  localparam logic [7:0] ADR_STATUS = 8'h82;
  localparam logic [7:0] ADR_CTRL   = 8'h83;
  localparam logic [7:0] ADR_WIN    = 8'h84;
  localparam logic [7:0] ADR_MIRROR = ADR_WIN + 8'(BLK_BYTES);

  localparam logic [2:0] MODE_ECB = 3'd0;
  localparam logic [2:0] MODE_KEY = 3'd1;
  localparam logic [2:0] MODE_CBC = 3'd2;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_e;
endpackage

// File: rtl/aesw_spi_phy.sv
module aesw_spi_phy #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       spi_miso,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       frame_start
);
  logic [SYNC_STAGES-1:0] sck_s, cs_s, mo_s;
  logic       sck_d, cs_d;
  logic       sck, cs, mo, rise, fall;
  logic [2:0] bitcnt;
  logic [7:0] rx_sh, tx_sh;

  assign sck = sck_s[SYNC_STAGES-1];
  assign cs  = cs_s[SYNC_STAGES-1];
  assign mo  = mo_s[SYNC_STAGES-1];
  assign rise = sck & ~sck_d & ~cs;
  assign fall = ~sck & sck_d & ~cs;
  assign frame_start = cs_d & ~cs;
  assign spi_miso = tx_sh[7];

  // Synchronise the SPI pins into the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= '1;
      mo_s  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_s <= {sck_s[SYNC_STAGES-2:0], spi_sclk};
      cs_s  <= {cs_s[SYNC_STAGES-2:0], spi_cs_n};
      mo_s  <= {mo_s[SYNC_STAGES-2:0], spi_mosi};
      sck_d <= sck;
      cs_d  <= cs;
    end
  end

  // Shift in on rising SCK; shift out on falling SCK, but not across a byte boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs) begin
        bitcnt <= '0;
        tx_sh  <= '0;
      end else begin
        if (rise) begin
          rx_sh  <= {rx_sh[6:0], mo};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_byte  <= {rx_sh[6:0], mo};
          end
        end
        if (tx_load) tx_sh <= tx_byte;
        else if (fall && bitcnt != 3'd0) tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  a_r13_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs |=> !spi_miso);
  a_r2_byte_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!cs));
endmodule

// File: rtl/aesw_core_stub.sv
module aesw_core_stub
  import aesw_pkg::*;
#(
  parameter int LATENCY = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [BLK_W-1:0] key,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] result
);
  localparam int LW = $clog2(LATENCY + 1);
  logic [LW-1:0]    left;
  logic [BLK_W-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left   <= '0;
      pend   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        pend <= blk_in ^ (dir ? ~key : key);
        left <= LW'(LATENCY);
        busy <= 1'b1;
      end else if (busy) begin
        if (left == LW'(1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= pend;
          left   <= '0;
        end else begin
          left <= left - LW'(1);
        end
      end
    end
  end

  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r4_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

// File: rtl/aesw_regs.sv
module aesw_regs
  import aesw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             core_busy,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_result,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  output logic             core_start,
  output logic             core_dir,
  output logic [BLK_W-1:0] core_in,
  output logic [BLK_W-1:0] core_key
);
  phase_e           phase;
  logic             is_wr;
  logic [7:0]       addr;
  logic [2:0]       mode;
  logic             done, err;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] dbuf;
  logic [7:0]       win_off;
  logic             in_win, wr_stb, full;

  assign win_off = addr - ADR_WIN;
  assign in_win  = win_off < 8'(BLK_BYTES);
  assign wr_stb  = rx_valid && phase == PH_DATA && is_wr;
  assign full    = cnt == CNT_W'(BLK_BYTES);

  function automatic logic [7:0] rd_val(input logic [7:0] a);
    logic [7:0] off;
    off = a - ADR_WIN;
    if (a == ADR_STATUS) return {err, 6'b0, done};
    if (a == ADR_CTRL || a == ADR_MIRROR) return {1'b0, mode, core_dir, 3'b0};
    if (off < 8'(BLK_BYTES))
      return (mode == MODE_KEY) ? ~core_key[off[3:0]*8 +: 8] : core_result[off[3:0]*8 +: 8];
    return 8'h00;
  endfunction

  // Command/address decode and the byte returned on MISO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      is_wr   <= 1'b0;
      addr    <= '0;
      tx_load <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_load <= rx_valid;
      if (frame_start) phase <= PH_CMD;
      else if (rx_valid) begin
        tx_byte <= 8'h00;
        case (phase)
          PH_CMD: begin
            is_wr <= rx_byte == CMD_WR;
            phase <= (rx_byte == CMD_WR || rx_byte == CMD_RD) ? PH_ADDR : PH_SKIP;
          end
          PH_ADDR: begin
            addr  <= rx_byte;
            phase <= PH_DATA;
            if (!is_wr) tx_byte <= rd_val(rx_byte);
          end
          PH_DATA: begin
            addr    <= addr + 8'd1;
            tx_byte <= is_wr ? rd_val(addr) : rd_val(addr + 8'd1);
          end
          default: ;
        endcase
      end
    end
  end

  // Register writes, start requests and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_ECB;
      core_dir   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      cnt        <= '0;
      dbuf       <= '0;
      core_key   <= '0;
      core_in    <= '0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (core_done) done <= 1'b1;
      if (wr_stb) begin
        if (addr == ADR_CTRL) begin
          mode     <= rx_byte[6:4];
          core_dir <= rx_byte[3];
          cnt      <= '0;
          if (core_busy) err <= 1'b1;
        end else if (in_win) begin
          if (mode == MODE_KEY) core_key[win_off[3:0]*8 +: 8] <= rx_byte;
          else                  dbuf[win_off[3:0]*8 +: 8]     <= rx_byte;
          if (!full) cnt <= cnt + CNT_W'(1);
        end else if (addr == ADR_MIRROR) begin
          mode     <= rx_byte[6:4];
          core_dir <= rx_byte[3];
          if (rx_byte[7]) begin
            if (full && !core_busy) begin
              core_in    <= (rx_byte[6:4] == MODE_CBC) ? (dbuf ^ core_result) : dbuf;
              core_start <= 1'b1;
              done       <= 1'b0;
              err        <= 1'b0;
              cnt        <= '0;
            end else begin
              err <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r12_start_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !done && !err);
  a_r8_short_request_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == ADR_MIRROR && rx_byte[7] && !full) |=> err && !core_start);
  a_r9_rewrite_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == ADR_CTRL && core_busy) |=> err);
  a_r4_done_follows_core: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> done);
  a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && phase == PH_DATA && !frame_start) |=> addr == $past(addr) + 8'd1);
endmodule

// File: rtl/aesw_spi_slave.sv
module aesw_spi_slave
  import aesw_pkg::*;
#(
  parameter int LATENCY     = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic             rx_valid, frame_start, tx_load;
  logic [7:0]       rx_byte, tx_byte;
  logic             core_start, core_dir, core_busy, core_done;
  logic [BLK_W-1:0] core_in, core_key, core_result;

  aesw_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .spi_miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_start(frame_start)
  );

  aesw_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .core_busy(core_busy), .core_done(core_done), .core_result(core_result),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .core_start(core_start), .core_dir(core_dir),
    .core_in(core_in), .core_key(core_key)
  );

  aesw_core_stub #(.LATENCY(LATENCY)) u_core (
    .clk(clk), .rst_n(rst_n),
    .start(core_start), .dir(core_dir), .blk_in(core_in), .key(core_key),
    .busy(core_busy), .done(core_done), .result(core_result)
  );
endmodule

// File: tb/test_aesw_spi_slave.sv
module test_aesw_spi_slave;
  localparam int H   = 8;
  localparam int LAT = 1200;
  localparam logic [127:0] KEY = 128'h00112233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] BA  = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] BB  = 128'h13579bdf_2468ace0_fedcba98_76543210;
  localparam logic [127:0] BC  = 128'hdeadbeef_cafef00d_01234567_89abcdef;
  localparam logic [127:0] BD  = 128'h55aa55aa_a5a5a5a5_3c3c3c3c_c3c3c3c3;
  localparam logic [127:0] BE  = 128'h11223344_55667788_99aabbcc_ddeeff00;

  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  aesw_spi_slave #(.LATENCY(LAT)) i_aesw_spi_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = o[b];
      repeat (H) @(negedge clk);
      i[b] = spi_miso;
      spi_sclk = 1;
      repeat (H) @(negedge clk);
      spi_sclk = 0;
    end
  endtask

  task automatic open_frame();
    spi_cs_n = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (H) @(negedge clk);
    spi_cs_n = 1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic rd_bytes(input logic [7:0] a, input int n, output logic [127:0] v);
    logic [7:0] q;
    v = '0;
    open_frame();
    xfer(8'h00, q);
    xfer(a, q);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, q);
      v[k*8 +: 8] = q;
    end
    close_frame();
  endtask

  task automatic wr_bytes(input logic [7:0] a, input int n, input logic [127:0] v);
    logic [7:0] q;
    open_frame();
    xfer(8'h40, q);
    xfer(a, q);
    for (int k = 0; k < n; k++) xfer(v[k*8 +: 8], q);
    close_frame();
  endtask

  task automatic wr_block(input logic [7:0] ctrl, input logic [127:0] blk,
                          input logic [7:0] mir, output logic [127:0] lag);
    logic [7:0] q;
    lag = '0;
    open_frame();
    xfer(8'h40, q);
    xfer(8'h83, q);
    xfer(ctrl, q);
    for (int k = 0; k < 16; k++) begin
      xfer(blk[k*8 +: 8], q);
      if (k > 0) lag[(k-1)*8 +: 8] = q;
    end
    xfer(mir, q);
    lag[127:120] = q;
    close_frame();
  endtask

  task automatic t_reset();
    logic [127:0] v;
    rd_bytes(8'h82, 2, v);
    chk("R1 status after reset", v[7:0], 8'h00);
    chk("R1 control after reset", v[15:8], 8'h00);
  endtask

  task automatic t_key();
    logic [127:0] v;
    wr_bytes(8'h83, 1, 128'h10);
    wr_bytes(8'h84, 16, KEY);
    rd_bytes(8'h84, 16, v);
    chk("R10 key readback inverted", v, ~KEY);
    rd_bytes(8'h92, 3, v);
    chk("R2 read auto-increment", v[23:0], {8'h10, ~KEY[127:112]});
    rd_bytes(8'h83, 1, v);
    chk("R3 control readback key mode", v[7:0], 8'h10);
  endtask

  task automatic t_ecb();
    logic [127:0] v, lag;
    wr_block(8'h00, BA, 8'h80, lag);
    rd_bytes(8'h82, 1, v);
    chk("R4 done clear while running", v[7:0], 8'h00);
    repeat (LAT + 100) @(negedge clk);
    rd_bytes(8'h82, 1, v);
    chk("R4 done after latency", v[7:0], 8'h01);
    rd_bytes(8'h84, 16, v);
    chk("R5 ECB encrypt result", v, BA ^ KEY);
    wr_block(8'h00, BB, 8'h80, lag);
    chk("R6 lagged result on MISO", lag, BA ^ KEY);
    repeat (LAT + 100) @(negedge clk);
    wr_block(8'h00, BC, 8'h00, lag);
    chk("R6 drain with idle mirror", lag, BB ^ KEY);
    repeat (LAT + 100) @(negedge clk);
    rd_bytes(8'h82, 1, v);
    chk("R7 idle mirror keeps done", v[7:0], 8'h01);
    rd_bytes(8'h84, 16, v);
    chk("R7 idle mirror keeps result", v, BB ^ KEY);
  endtask

  task automatic t_dec_cbc();
    logic [127:0] v, lag;
    wr_block(8'h08, BC, 8'h88, lag);
    repeat (LAT + 100) @(negedge clk);
    rd_bytes(8'h84, 16, v);
    chk("R5 ECB decrypt result", v, BC ^ ~KEY);
    rd_bytes(8'h94, 1, v);
    chk("R3 mirror readback", v[7:0], 8'h08);
    wr_block(8'h20, BD, 8'hA0, lag);
    repeat (LAT + 100) @(negedge clk);
    rd_bytes(8'h84, 16, v);
    chk("R11 CBC chaining", v, BD ^ (BC ^ ~KEY) ^ KEY);
    rd_bytes(8'h83, 1, v);
    chk("R3 control readback CBC", v[7:0], 8'h20);
  endtask

  task automatic t_errors();
    logic [127:0] v, lag, prev;
    prev = BD ^ BC ^ ~KEY ^ KEY;
    wr_bytes(8'h83, 11, {80'h0, 40'h0102030405, 8'h00});
    wr_bytes(8'h94, 1, 128'h80);
    rd_bytes(8'h82, 1, v);
    chk("R8 short block error", v[7:0], 8'h81);
    rd_bytes(8'h84, 16, v);
    chk("R8 no start on short block", v, prev);
    wr_block(8'h00, BE, 8'h80, lag);
    rd_bytes(8'h82, 1, v);
    chk("R12 start clears error and done", v[7:0], 8'h00);
    wr_bytes(8'h83, 1, 128'h00);
    repeat (LAT + 100) @(negedge clk);
    rd_bytes(8'h82, 1, v);
    chk("R9 rewrite while busy flags error", v[7:0], 8'h81);
    rd_bytes(8'h84, 16, v);
    chk("R5 result after error run", v, BE ^ KEY);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] q0, q1, q2;
    logic [127:0] v;
    open_frame();
    xfer(8'h20, q0);
    xfer(8'h83, q1);
    xfer(8'h28, q2);
    close_frame();
    chk("R13 unknown command MISO", {q0, q1, q2}, 24'h0);
    rd_bytes(8'h83, 1, v);
    chk("R13 unknown command writes nothing", v[7:0], 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_key();
    t_ecb();
    t_dec_cbc();
    t_errors();
    t_bad_cmd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule